// File: doc/BRIEF.md
# Memory Address-Line Walking Test Engine

This block is a self-timed sequencer that hunts for broken RAM address lines. A broken line makes two addresses that differ only in that line land on one physical word, so a write to one of them shows up when the other is read. Given a byte base address, a region length in bytes and a test address, the engine flips one address bit at a time, starting at the lowest bit above word granularity. For every flipped address that lies inside the region it reads that word, stores the complement of the value at the test address, and reads the flipped address again. If the second read returns the complement, the two addresses alias and the engine stops with a fault report.

One start runs the walk twice. The first walk uses the bottom word of the region as the test address and the second uses the top word, so line faults that only show up at one end of a region that does not start at zero are still found. The second walk is left out when the first one has already found a fault. The engine drives a plain single-port memory master: a request strobe, a write enable, a word address and write data, with read data returned one cycle after a read request.

Top module: `addrline_walk_engine`

## Requirements
- R1: While reset is high and in the cycle after it, done and fail are low and mem_req is low; a reset during or after a run drops a held result.
- R2: The flip mask starts at the word size in bytes (8 for 64-bit data) and doubles on each step; the step with the top address bit (bit ADDR_W-1) is the last of a walk. On a fault, fail_mask holds exactly one set bit, never below the word size.
- R3: Each target is the test address XOR the mask. A target is used only if base_addr <= target < base_addr + region_bytes; for any other target the step makes no memory access at all.
- R4: For a used target the port sees, in this order: a read of the target, then a write to the test address of the bitwise complement of the read data, then a second read of the target. mem_addr is the byte address shifted right by 3 (64-bit words); mem_rdata is taken in the cycle after the read request.
- R5: If the second read of a target equals the value just written, the run stops and fail rises with done, and fail_test_addr, fail_target_addr and fail_mask hold the test address, the target and the mask of that step.
- R6: The first walk uses base_addr as test address; the second uses base_addr + region_bytes - 8. The second walk runs only if the first found no fault.
- R7: done stays high, the result stays unchanged and no memory access happens until the next start; a start clears done and fail in the next cycle.
- R8: On a memory with no aliasing, both walks complete and the run ends with done high and fail low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or finished) |
| base_addr | input | ADDR_W | Byte address of the first word of the region |
| region_bytes | input | ADDR_W+1 | Region length in bytes, a multiple of the word size |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| done | output | 1 | Run finished; held until the next start |
| fail | output | 1 | An alias was found |
| fail_test_addr | output | ADDR_W | Test address of the failing step |
| fail_target_addr | output | ADDR_W | Target address of the failing step |
| fail_mask | output | ADDR_W | Flip mask of the failing step |

## Verification
Alias detection and the end of a walk can fall on the same compare cycle: when the top address bit is the broken one, the fault is seen on the last step of the first walk, exactly where the engine would otherwise switch to the second walk. This is provoked with the top word-address bit of the bench RAM tied high over a region starting at zero, and judged by the captured test address being the base rather than the top word and by the write count stopping at seven. A fault visible only from the top word, a region whose upper flips all fall outside it, and a fault on the first step round out the vectors.

// File: rtl/aw_pkg.sv
package aw_pkg;

    // Sequencer states of the walk engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,    // range check of the current target, first read
        ST_CAP,     // read data arrives, complement captured
        ST_WR,      // complement written to the test address
        ST_RD2,     // target read again
        ST_CMP,     // second read data compared
        ST_DONE
    } aw_state_e;

    // Which end of the region supplies the test address.
    typedef enum logic {
        PASS_FROM_BASE = 1'b0,
        PASS_FROM_TOP  = 1'b1
    } aw_pass_e;

endpackage

// File: rtl/aw_mask_walk.sv
module aw_mask_walk #(
    parameter int ADDR_W     = 10,
    parameter int WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    output logic [ADDR_W-1:0] mask,
    output logic              last
);
    localparam logic [ADDR_W-1:0] FIRST_MASK = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= FIRST_MASK;
        end else if (load) begin
            mask <= FIRST_MASK;
        end else if (advance) begin
            mask <= mask << 1;
        end
    end

    assign last = mask[ADDR_W-1];
endmodule

// File: rtl/aw_target_gen.sv
module aw_target_gen #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] test_addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W:0]   region_bytes,
    output logic [ADDR_W-1:0] target,
    output logic              in_region
);
    logic [ADDR_W:0] region_end;

    always_comb begin
        target     = test_addr ^ mask;
        region_end = {1'b0, base_addr} + region_bytes;
        in_region  = (target >= base_addr) && ({1'b0, target} < region_end);
    end
endmodule

// File: rtl/aw_fault_log.sv
module aw_fault_log #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  logic [ADDR_W-1:0] test_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] mask,
    output logic              found,
    output logic [ADDR_W-1:0] log_test,
    output logic [ADDR_W-1:0] log_target,
    output logic [ADDR_W-1:0] log_mask
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found      <= 1'b0;
            log_test   <= '0;
            log_target <= '0;
            log_mask   <= '0;
        end else if (capture) begin
            found      <= 1'b1;
            log_test   <= test_addr;
            log_target <= target;
            log_mask   <= mask;
        end
    end
endmodule

// File: rtl/addrline_walk_engine.sv
module addrline_walk_engine
    import aw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [ADDR_W:0]               region_bytes,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          done,
    output logic                          fail,
    output logic [ADDR_W-1:0]             fail_test_addr,
    output logic [ADDR_W-1:0]             fail_target_addr,
    output logic [ADDR_W-1:0]             fail_mask
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);

    aw_state_e         state_q, state_d;
    aw_pass_e          pass_q, pass_d;
    logic [ADDR_W-1:0] test_q, test_d;
    logic [DATA_W-1:0] wr_val_q;
    logic [ADDR_W-1:0] mask, target;
    logic              mask_last, in_region;
    logic              mask_load, mask_adv, step_over;
    logic              log_clear, log_capture;
    logic [ADDR_W:0]   top_word;

    assign top_word = {1'b0, base_addr} + region_bytes - (ADDR_W+1)'(WORD_BYTES);

    aw_mask_walk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) mask_i (
        .clk     (clk),
        .rst     (rst),
        .load    (mask_load),
        .advance (mask_adv),
        .mask    (mask),
        .last    (mask_last)
    );

    aw_target_gen #(.ADDR_W(ADDR_W)) tgt_i (
        .test_addr    (test_q),
        .mask         (mask),
        .base_addr    (base_addr),
        .region_bytes (region_bytes),
        .target       (target),
        .in_region    (in_region)
    );

    aw_fault_log #(.ADDR_W(ADDR_W)) log_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (log_clear),
        .capture    (log_capture),
        .test_addr  (test_q),
        .target     (target),
        .mask       (mask),
        .found      (fail),
        .log_test   (fail_test_addr),
        .log_target (fail_target_addr),
        .log_mask   (fail_mask)
    );

    always_comb begin
        state_d     = state_q;
        pass_d      = pass_q;
        test_d      = test_q;
        mask_load   = 1'b0;
        mask_adv    = 1'b0;
        step_over   = 1'b0;
        log_clear   = 1'b0;
        log_capture = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = target[ADDR_W-1:WORD_SHIFT];

        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d   = ST_STEP;
                    pass_d    = PASS_FROM_BASE;
                    test_d    = base_addr;
                    mask_load = 1'b1;
                    log_clear = 1'b1;
                end
            end
            ST_STEP: begin
                if (in_region) begin
                    mem_req = 1'b1;
                    state_d = ST_CAP;
                end else begin
                    step_over = 1'b1;
                end
            end
            ST_CAP: state_d = ST_WR;
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = test_q[ADDR_W-1:WORD_SHIFT];
                state_d  = ST_RD2;
            end
            ST_RD2: begin
                mem_req = 1'b1;
                state_d = ST_CMP;
            end
            ST_CMP: begin
                if (mem_rdata == wr_val_q) begin
                    log_capture = 1'b1;
                    state_d     = ST_DONE;
                end else begin
                    step_over = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        // Move to the next mask, the next walk, or the end of the run.
        if (step_over) begin
            state_d = ST_STEP;
            if (!mask_last) begin
                mask_adv = 1'b1;
            end else if (pass_q == PASS_FROM_BASE) begin
                pass_d    = PASS_FROM_TOP;
                test_d    = top_word[ADDR_W-1:0];
                mask_load = 1'b1;
            end else begin
                state_d = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pass_q   <= PASS_FROM_BASE;
            test_q   <= '0;
            wr_val_q <= '0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            test_q  <= test_d;
            if (state_q == ST_CAP) begin
                wr_val_q <= ~mem_rdata;
            end
        end
    end

    assign mem_wdata = wr_val_q;
    assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/aw_checker.sv
module aw_checker #(
    parameter int ADDR_W     = 10,
    parameter int WORD_BYTES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_test_addr,
    input logic [ADDR_W-1:0] fail_target_addr,
    input logic [ADDR_W-1:0] fail_mask
);
    // R4: a write is always followed by the second read of the target
    assert_read_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (mem_req && !mem_we));

    // R4: a write is always preceded, two cycles before, by the first read
    assert_read_before_write_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

    // R5: a fault is only reported with a finished run
    assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R2: the reported mask is a single bit at or above word granularity
    assert_mask_single_bit_R2: assert property (@(posedge clk) disable iff (rst)
        fail |-> ($countones(fail_mask) == 1 && fail_mask >= ADDR_W'(WORD_BYTES)));

    // R3: reported test and target differ exactly by the reported mask
    assert_pair_by_mask_R3: assert property (@(posedge clk) disable iff (rst)
        fail |-> ((fail_test_addr ^ fail_target_addr) == fail_mask));

    // R7: the result holds until a new start
    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_mask)));

    // R7: no memory traffic once the run has finished
    assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind addrline_walk_engine aw_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .start            (start),
    .mem_req          (mem_req),
    .mem_we           (mem_we),
    .done             (done),
    .fail             (fail),
    .fail_test_addr   (fail_test_addr),
    .fail_target_addr (fail_target_addr),
    .fail_mask        (fail_mask)
);

// File: tb/addrline_walk_engine_tb.sv
module addrline_walk_engine_tb_top;
    localparam int AW    = 10;
    localparam int DW    = 64;
    localparam int WAW   = AW - 3;
    localparam int WORDS = 1 << WAW;

    // fmode: 0 no fault, 1 word-address bit fbit tied low, 2 tied high
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW:0]   size;
        logic [1:0]    fmode;
        logic [2:0]    fbit;
        logic          exp_fail;
        logic [AW-1:0] exp_test;
        logic [AW-1:0] exp_tgt;
        logic [AW-1:0] exp_mask;
        logic [4:0]    exp_wr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{10'h000, 11'h400, 2'd0, 3'd0, 1'b0, 10'h000, 10'h000, 10'h000, 5'd14},
        '{10'h000, 11'h400, 2'd1, 3'd2, 1'b1, 10'h000, 10'h020, 10'h020, 5'd3},
        '{10'h000, 11'h400, 2'd2, 3'd6, 1'b1, 10'h000, 10'h200, 10'h200, 5'd7},
        '{10'h100, 11'h100, 2'd0, 3'd0, 1'b0, 10'h000, 10'h000, 10'h000, 5'd10},
        '{10'h100, 11'h100, 2'd1, 3'd6, 1'b0, 10'h000, 10'h000, 10'h000, 5'd10},
        '{10'h100, 11'h100, 2'd2, 3'd0, 1'b1, 10'h100, 10'h108, 10'h008, 5'd1},
        '{10'h100, 11'h300, 2'd1, 3'd5, 1'b1, 10'h3F8, 10'h2F8, 10'h100, 5'd12}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic [AW:0]    region_bytes = '0;
    logic           mem_req, mem_we;
    logic [WAW-1:0] mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata;
    logic           done, fail;
    logic [AW-1:0]  fail_test_addr, fail_target_addr, fail_mask;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    addrline_walk_engine #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .start            (start),
        .base_addr        (base_addr),
        .region_bytes     (region_bytes),
        .mem_req          (mem_req),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_wdata        (mem_wdata),
        .mem_rdata        (mem_rdata),
        .done             (done),
        .fail             (fail),
        .fail_test_addr   (fail_test_addr),
        .fail_target_addr (fail_target_addr),
        .fail_mask        (fail_mask)
    );

    // RAM model with an injectable stuck address line, one-cycle read.
    logic [DW-1:0]  ram [WORDS];
    logic [1:0]     fault_mode = 2'd0;
    logic [2:0]     fault_bit  = 3'd0;
    logic           ram_init   = 1'b0;
    logic [WAW-1:0] phys;
    int             wr_cnt = 0;
    int             wr_bad = 0;

    always_comb begin
        phys = mem_addr;
        if (fault_mode == 2'd1) phys[fault_bit] = 1'b0;
        if (fault_mode == 2'd2) phys[fault_bit] = 1'b1;
    end

    always @(posedge clk) begin
        if (ram_init) begin
            for (int i = 0; i < WORDS; i++)
                ram[i] <= {32'(i) * 32'h9E3779B9, 32'(i) ^ 32'hC3A51F00};
            mem_rdata <= '0;
            wr_cnt    <= 0;
            wr_bad    <= 0;
        end else if (mem_req) begin
            if (mem_we) begin
                ram[phys] <= mem_wdata;
                wr_cnt    <= wr_cnt + 1;
                if (mem_wdata != ~mem_rdata) wr_bad <= wr_bad + 1;
            end else begin
                mem_rdata <= ram[phys];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int n;
        logic [AW-1:0] held_mask;
        @(negedge clk);
        fault_mode   = v.fmode;
        fault_bit    = v.fbit;
        base_addr    = v.base;
        region_bytes = v.size;
        ram_init     = 1'b1;
        @(negedge clk);
        ram_init = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && !fail, $sformatf("R7 start clears result v%0d", idx), {30'd0, done, fail}, 32'd0);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done, $sformatf("R8 run finishes v%0d", idx), 32'(done), 32'd1);
        if (v.exp_fail) begin
            check(fail, $sformatf("R5 fault flagged v%0d", idx), 32'(fail), 32'd1);
            check(fail_test_addr == v.exp_test, $sformatf("R6 test address v%0d", idx),
                  32'(fail_test_addr), 32'(v.exp_test));
            check(fail_target_addr == v.exp_tgt, $sformatf("R3 target address v%0d", idx),
                  32'(fail_target_addr), 32'(v.exp_tgt));
            check(fail_mask == v.exp_mask, $sformatf("R2 mask v%0d", idx),
                  32'(fail_mask), 32'(v.exp_mask));
        end else begin
            check(!fail, $sformatf("R8 clean pass v%0d", idx), 32'(fail), 32'd0);
        end
        check(wr_cnt == int'(v.exp_wr), $sformatf("R3 steps taken (writes) v%0d", idx),
              32'(wr_cnt), 32'(v.exp_wr));
        check(wr_bad == 0, $sformatf("R4 complement written v%0d", idx), 32'(wr_bad), 32'd0);
        held_mask = fail_mask;
        repeat (4) @(negedge clk);
        check(done && (fail == v.exp_fail) && !mem_req && (fail_mask == held_mask),
              $sformatf("R7 result held v%0d", idx), {22'd0, fail_mask}, {22'd0, held_mask});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && !fail && !mem_req, "R1 reset state", {29'd0, done, fail, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !fail && !mem_req, "R1 idle after reset", {29'd0, done, fail, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // Reset drops a held fault result.
        check(fail && done, "R1 fault held before reset", {30'd0, done, fail}, 32'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !fail && !mem_req, "R1 reset clears result", {29'd0, done, fail, mem_req}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule